// File: doc/BRIEF.md
# Indirect Register Access Port

This block is a small host bus slave that opens a wide internal register space through three directly addressed locations. The host first sets a 16-bit register index, then reaches the selected internal register through a byte-wide data window. One data write produces a write strobe to the internal register file. One data read returns the register value one cycle later.

The host bus runs in one of two widths, chosen by the `wideMode` pin. In narrow (8-bit) mode the index is built from two byte writes, one to a low location and one to a high location. In wide (16-bit) mode the whole index is loaded by one write to the low location, and the high location plays no part. On the internal side the block drives a plain register file interface: index, write strobe, write data, and combinational read data coming back.

The direct address map is fixed, because the host software depends on it. Address 0 holds the low index byte and is write-only. Address 1 holds the high index byte and is write-only. Address 2 is the data window, which can be read and written. Address 3 is unmapped.

Top module: `indirect_reg_port`

## Requirements
- R1: While `rst` is high and after its release, `regIdx` is 0, `regWe` is 0, `hostRvalid` is 0 and `hostRdata` is 0.
- R2: With `wideMode`=0, a write to address 0 copies `hostWdata[7:0]` into `regIdx[7:0]`, and `regIdx[15:8]` is unchanged from the next cycle on.
- R3: With `wideMode`=0, a write to address 1 copies `hostWdata[7:0]` into `regIdx[15:8]`, and `regIdx[7:0]` is unchanged from the next cycle on.
- R4: With `wideMode`=1, a write to address 0 loads all 16 bits of `hostWdata` into `regIdx` from the next cycle on.
- R5: With `wideMode`=1, a write to address 1 leaves `regIdx` unchanged.
- R6: A write to address 2 raises `regWe` in the same cycle as the access, and only in that cycle, with `regWdata` equal to `hostWdata[7:0]` and `regIdx` equal to the current index.
- R7: A read of address 2 gives `hostRvalid`=1 in the next cycle. In that cycle `hostRdata[7:0]` holds the register value at the current index and `hostRdata[15:8]` is 0.
- R8: A read of address 0, 1 or 3 gives `hostRvalid`=1 with `hostRdata`=0 in the next cycle, and leaves `regIdx` unchanged.
- R9: Reads and writes of address 2 never change `regIdx`. The index does not advance on its own.
- R10: A write to address 3 changes neither `regIdx` nor `regWe`.
- R11: In the cycle after any access that is not a read, and after an idle cycle, `hostRvalid` is 0 and `hostRdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wideMode | input | 1 | 1 selects the 16-bit host bus, 0 the 8-bit host bus |
| hostSel | input | 1 | Host access in this cycle |
| hostWr | input | 1 | 1 for a write, 0 for a read |
| hostAddr | input | 2 | Direct location: 0 index low, 1 index high, 2 data, 3 unmapped |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Read data, valid the cycle after a read |
| hostRvalid | output | 1 | Read data valid |
| regIdx | output | 16 | Index of the selected internal register |
| regWe | output | 1 | Internal register write strobe |
| regWdata | output | 8 | Internal register write data |
| regRdata | input | 8 | Internal register read data, combinational from `regIdx` |

## Verification
The bench loads the index through every route: the narrow byte pair in both orders, the wide single write, narrow writes whose upper data bits are set, and the ignored high location in wide mode. A design that merged the wrong lane or loaded the wrong half would then select the wrong register. Data writes and reads alternate at the index extremes and on back-to-back cycles. An index that advanced, a strobe landing on the wrong index, or read data captured a cycle late would each show up as a mismatch on the data read back. Reads of the write-only and unmapped locations must return zero. A design that passed register data or left stale data on the bus would fail that check, as would one whose valid flag stayed high after a write.

// File: rtl/irp_pkg.sv
package irp_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] LOC_IDX_LO = 2'd0;
  localparam logic [ADDR_W-1:0] LOC_IDX_HI = 2'd1;
  localparam logic [ADDR_W-1:0] LOC_DATA   = 2'd2;

  typedef struct packed {
    logic loadLo;    // narrow: low index lane from host low byte
    logic loadHi;    // narrow: high index lane from host low byte
    logic loadFull;  // wide: every lane from its own host lane
    logic dataWr;    // write strobe to internal register
    logic dataRd;    // capture internal read data
    logic anyRd;     // some read this cycle
  } irpStrobe_t;
endpackage

// File: rtl/irp_ctrl.sv
module irp_ctrl
  import irp_pkg::*;
(
  input  logic              wideMode,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  output irpStrobe_t        strobes
);
  logic isWrite;
  logic isRead;

  assign isWrite = hostSel && hostWr;
  assign isRead  = hostSel && !hostWr;

  always_comb begin
    strobes          = '0;
    strobes.anyRd    = isRead;
    strobes.dataRd   = isRead && (hostAddr == LOC_DATA);
    strobes.dataWr   = isWrite && (hostAddr == LOC_DATA);
    strobes.loadFull = isWrite && wideMode && (hostAddr == LOC_IDX_LO);
    strobes.loadLo   = isWrite && !wideMode && (hostAddr == LOC_IDX_LO);
    strobes.loadHi   = isWrite && !wideMode && (hostAddr == LOC_IDX_HI);
  end
endmodule

// File: rtl/irp_datapath.sv
module irp_datapath
  import irp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  irpStrobe_t          strobes,
  input  logic [2*DATA_W-1:0] hostWdata,
  output logic [2*DATA_W-1:0] hostRdata,
  output logic                hostRvalid,
  output logic [2*DATA_W-1:0] regIdx,
  output logic                regWe,
  output logic [DATA_W-1:0]   regWdata,
  input  logic [DATA_W-1:0]   regRdata
);
  localparam int LANES  = 2;
  localparam int HOST_W = LANES * DATA_W;

  logic [DATA_W-1:0] idxLane [LANES];

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic laneNarrowHit;
    logic [DATA_W-1:0] laneSrc;
    if (lane == 0) begin : g_lo
      assign laneNarrowHit = strobes.loadLo;
    end else begin : g_hi
      assign laneNarrowHit = strobes.loadHi;
    end
    assign laneSrc = strobes.loadFull ? hostWdata[lane*DATA_W +: DATA_W]
                                      : hostWdata[DATA_W-1:0];
    always_ff @(posedge clk) begin
      if (rst)
        idxLane[lane] <= '0;
      else if (strobes.loadFull || laneNarrowHit)
        idxLane[lane] <= laneSrc;
    end
    assign regIdx[lane*DATA_W +: DATA_W] = idxLane[lane];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hostRvalid <= 1'b0;
      hostRdata  <= '0;
    end else begin
      hostRvalid <= strobes.anyRd;
      hostRdata  <= strobes.dataRd ? {{(HOST_W-DATA_W){1'b0}}, regRdata} : '0;
    end
  end

  assign regWe    = strobes.dataWr;
  assign regWdata = hostWdata[DATA_W-1:0];
endmodule

// File: rtl/indirect_reg_port.sv
module indirect_reg_port
  import irp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wideMode,
  input  logic                hostSel,
  input  logic                hostWr,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [2*DATA_W-1:0] hostWdata,
  output logic [2*DATA_W-1:0] hostRdata,
  output logic                hostRvalid,
  output logic [2*DATA_W-1:0] regIdx,
  output logic                regWe,
  output logic [DATA_W-1:0]   regWdata,
  input  logic [DATA_W-1:0]   regRdata
);
  irpStrobe_t strobes;

  irp_ctrl u_ctrl (
    .wideMode (wideMode),
    .hostSel  (hostSel),
    .hostWr   (hostWr),
    .hostAddr (hostAddr),
    .strobes  (strobes)
  );

  irp_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .hostWdata  (hostWdata),
    .hostRdata  (hostRdata),
    .hostRvalid (hostRvalid),
    .regIdx     (regIdx),
    .regWe      (regWe),
    .regWdata   (regWdata),
    .regRdata   (regRdata)
  );
endmodule

// File: rtl/irp_checker.sv
module irp_checker
  import irp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                wideMode,
  input logic                hostSel,
  input logic                hostWr,
  input logic [ADDR_W-1:0]   hostAddr,
  input logic [2*DATA_W-1:0] hostWdata,
  input logic [2*DATA_W-1:0] hostRdata,
  input logic                hostRvalid,
  input logic [2*DATA_W-1:0] regIdx,
  input logic                regWe,
  input logic [DATA_W-1:0]   regWdata,
  input logic [DATA_W-1:0]   regRdata
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (regIdx == '0 && !hostRvalid && hostRdata == '0));

  a_r4_wide_full_load: assert property (@(posedge clk) disable iff (rst)
    (hostSel && hostWr && wideMode && hostAddr == 2'd0) |=> regIdx == $past(hostWdata));

  a_r5_wide_hi_ignored: assert property (@(posedge clk) disable iff (rst)
    (hostSel && hostWr && wideMode && hostAddr == 2'd1) |=> $stable(regIdx));

  a_r6_strobe_needs_write: assert property (@(posedge clk) disable iff (rst)
    regWe |-> (hostSel && hostWr));

  a_r7_read_capture: assert property (@(posedge clk) disable iff (rst)
    (hostSel && !hostWr && hostAddr == 2'd2) |=>
      (hostRvalid && hostRdata == {{DATA_W{1'b0}}, $past(regRdata)}));

  a_r8_zero_read: assert property (@(posedge clk) disable iff (rst)
    (hostSel && !hostWr && hostAddr != 2'd2) |=> (hostRvalid && hostRdata == '0));

  a_r9_data_keeps_idx: assert property (@(posedge clk) disable iff (rst)
    (hostSel && hostAddr == 2'd2) |=> $stable(regIdx));

  a_r11_quiet_after_nonread: assert property (@(posedge clk) disable iff (rst)
    !(hostSel && !hostWr) |=> (!hostRvalid && hostRdata == '0));
endmodule

bind indirect_reg_port irp_checker #(.DATA_W(DATA_W)) u_irp_checker (.*);

// File: tb/test_indirect_reg_port.sv
module test_indirect_reg_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        wideMode;
  logic        hostSel;
  logic        hostWr;
  logic [1:0]  hostAddr;
  logic [15:0] hostWdata;
  logic [15:0] hostRdata;
  logic        hostRvalid;
  logic [15:0] regIdx;
  logic        regWe;
  logic [7:0]  regWdata;
  logic [7:0]  regRdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  indirect_reg_port i_indirect_reg_port (
    .clk(clk), .rst(rst), .wideMode(wideMode), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostRvalid(hostRvalid), .regIdx(regIdx), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata)
  );

  function automatic logic [7:0] seedVal(input logic [15:0] idx);
    return idx[7:0] ^ idx[15:8] ^ 8'h5A;
  endfunction

  // environment register file, written by the design's strobe
  logic [7:0] envMem [int];
  always @(posedge clk) if (!rst && regWe) envMem[int'(regIdx)] = regWdata;
  always_comb regRdata = envMem.exists(int'(regIdx)) ? envMem[int'(regIdx)] : seedVal(regIdx);

  // reference model, driven only by host-side intent
  logic [7:0]  expMem [int];
  logic [15:0] mIdx = '0;
  logic        mRvalid = 1'b0;
  logic [15:0] mRdata = '0;
  string       rdTag = "R11";
  string       idxTag = "R9";

  always @(posedge clk) begin
    if (rst) begin
      mIdx = '0; mRvalid = 1'b0; mRdata = '0; rdTag = "R1"; idxTag = "R1";
    end else begin
      mRvalid = hostSel && !hostWr;
      mRdata  = '0;
      rdTag   = "R11";
      idxTag  = "R9";
      if (hostSel && !hostWr) begin
        if (hostAddr == 2'd2) begin
          mRdata = {8'h00, expMem.exists(int'(mIdx)) ? expMem[int'(mIdx)] : seedVal(mIdx)};
          rdTag = "R7";
        end else begin
          rdTag = "R8"; idxTag = "R8";
        end
      end else if (hostSel && hostWr) begin
        case (hostAddr)
          2'd0: if (wideMode) begin mIdx = hostWdata; idxTag = "R4"; end
                else begin mIdx[7:0] = hostWdata[7:0]; idxTag = "R2"; end
          2'd1: if (!wideMode) begin mIdx[15:8] = hostWdata[7:0]; idxTag = "R3"; end
                else idxTag = "R5";
          2'd2: expMem[int'(mIdx)] = hostWdata[7:0];
          default: idxTag = "R10";
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic ok, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      logic expWe;
      expWe = hostSel && hostWr && hostAddr == 2'd2;
      check(rdTag, hostRvalid == mRvalid, {15'd0, hostRvalid}, {15'd0, mRvalid});
      check(rdTag, hostRdata == mRdata, hostRdata, mRdata);
      check(idxTag, regIdx == mIdx, regIdx, mIdx);
      check(expWe ? "R6" : "R10", regWe == expWe, {15'd0, regWe}, {15'd0, expWe});
      if (expWe) check("R6", regWdata == hostWdata[7:0], {8'd0, regWdata}, hostWdata);
    end
  end

  task automatic drive(input logic sel, input logic wr, input logic [1:0] addr, input logic [15:0] wd);
    @(negedge clk); #2;
    hostSel = sel; hostWr = wr; hostAddr = addr; hostWdata = wd;
  endtask

  task automatic wr(input logic [1:0] addr, input logic [15:0] wd); drive(1'b1, 1'b1, addr, wd); endtask
  task automatic rd(input logic [1:0] addr); drive(1'b1, 1'b0, addr, 16'hDEAD); endtask
  task automatic idle(); drive(1'b0, 1'b0, 2'd0, 16'h0); endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rst = 1'b1; wideMode = 1'b0; hostSel = 1'b0; hostWr = 1'b0; hostAddr = '0; hostWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", regIdx == 16'h0 && !regWe && !hostRvalid && hostRdata == 16'h0,
          regIdx, 16'h0);
    #2 rst = 1'b0;
    // narrow mode: index via byte pair, upper data bits must not leak
    wr(2'd0, 16'hFF34); wr(2'd1, 16'hEE12); rd(2'd2);
    wr(2'd2, 16'h77A5); rd(2'd2); rd(2'd2);
    rd(2'd0); rd(2'd1); rd(2'd3);
    wr(2'd3, 16'h5555); idle();
    // reversed byte order and extremes
    wr(2'd1, 16'h00FF); wr(2'd0, 16'h00FF); wr(2'd2, 16'h0011); rd(2'd2);
    wr(2'd1, 16'h0000); wr(2'd0, 16'h0000); rd(2'd2); wr(2'd2, 16'h0022); rd(2'd2);
    // wide mode
    idle(); wideMode = 1'b1;
    wr(2'd0, 16'hBEEF); wr(2'd1, 16'h0077); rd(2'd2);
    wr(2'd2, 16'hC3C3); rd(2'd2); wr(2'd0, 16'hFFFF); rd(2'd2);
    wr(2'd0, 16'h1234); rd(2'd2); rd(2'd0); idle();
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:29] == 3'd0) begin idle(); wideMode = r[28]; end
      else drive(1'b1, r[27], r[26:25], {r[24:17], 5'd0, r[2:0]});
    end
    idle(); idle();
    finishRun();
  end
endmodule